// File: doc/BRIEF.md
# Pulse-to-Reference Phase Interval Meter

This block measures, once per second, how far a one-pulse-per-second timing mark sits ahead of the next edge of a divided-down reference oscillator. A single 50 MHz counting clock samples both the timing pulse and the 10 MHz reference through two-stage synchronizers. The reference is divided by sixteen, so a comparison edge occurs every 80 counting-clock cycles. A counter built from cascaded 4-bit stages measures the number of counting-clock cycles from the detected pulse edge to the next comparison edge.

Each finished measurement is loaded into an 8-bit parallel-in, serial-out register, which a host reads most significant bit first. The same readings also feed an accumulator. It sums them over a window of 1 to 64 readings and, at the end of the window, emits a scaled total with a one-cycle strobe. Windows longer than 32 readings are halved per doubling, so a 64-reading window is divided by two. A divide-by-four output provides a 12.5 MHz system clock.

Top module: `phase_interval_meter`

## Requirements
- R1: After a rising edge of `pps_in`, the measurement equals the number of counting-clock cycles from that edge to the next divided-reference edge that lies strictly later, so values run from 1 to 80 with a nominal reference. A pulse edge that lands in the same cycle as a divided edge yields 80.
- R2: The divided-reference edge is every sixteenth rising edge of `ref_in`, counted from the end of reset (the 16th, 32nd, and so on).
- R3: If no divided edge arrives, the measurement stops growing at 255 and reports 255 when the measurement ends.
- R4: Each finished measurement is loaded into an 8-bit shift register. `sr_out` shows its most significant bit. Each cycle with `shift_en` high shifts it left by one place and fills with 0, so eight shifts return the value MSB first and leave `sr_out` at 0.
- R5: The accumulator closes a window after 2^`win_sel` readings (`win_sel` 0 to 6). The first window starts at the end of reset, and every window starts from a cleared sum.
- R6: When a window closes, `res_value` holds the window sum shifted right by (`win_sel` − 5) when `win_sel` > 5 and unshifted otherwise. `res_valid` is high for exactly one cycle.
- R7: `sys_clk_out` runs at a quarter of `clk`, two cycles high and two cycles low.
- R8: While reset is asserted, `sr_out`, `res_valid`, `res_value` and `sys_clk_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz counting clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pps_in | input | 1 | One-pulse-per-second timing mark, asynchronous |
| ref_in | input | 1 | 10 MHz reference oscillator, sampled by `clk` |
| win_sel | input | 3 | Log2 of readings per window; values above 6 act as 6 |
| shift_en | input | 1 | Shift the readout register by one bit this cycle |
| sr_out | output | 1 | Serial readout, MSB of the readout register |
| res_valid | output | 1 | One-cycle strobe at window close |
| res_value | output | 16 | Scaled window sum |
| sys_clk_out | output | 1 | 12.5 MHz system clock |

## Verification
The pulse is placed at several offsets against the comparison edges. These include one cycle before an edge, on the edge, one cycle after it, and mid-period points. This separates the off-by-one in the count start and the strictly-later stop rule, and it confirms the divide-by-sixteen phase. Windows of 8, 1 and 64 readings show whether the window length, the clearing between windows and the halving for the longest window are right. Removing the reference for several hundred cycles exposes a wrapping counter. Shifting past eight bits shows the zero fill.

// File: rtl/pim_pkg.sv
package pim_pkg;
  // Depth of the synchronizers on asynchronous inputs and on reset release
  localparam int SYNC_DEPTH = 2;

  // Number of readings in a window for a clamped selector
  function automatic int win_len(input int sel_log);
    return 1 << sel_log;
  endfunction
endpackage

// File: rtl/pim_sync_edge.sv
module pim_sync_edge #(
  parameter int STAGES = pim_pkg::SYNC_DEPTH
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] chain_q, chain_d;
  logic              prev_q, prev_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], async_in};
    prev_d  = chain_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      prev_q  <= prev_d;
    end
  end

  assign rise = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/pim_count_stage.sv
module pim_count_stage #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         inc,
  output logic [W-1:0] q
);
  logic [W-1:0] q_q, q_d;

  always_comb begin
    q_d = q_q;
    if (ld)
      q_d = ld_val;
    else if (inc)
      q_d = q_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      q_q <= '0;
    else
      q_q <= q_d;
  end

  assign q = q_q;
endmodule

// File: rtl/pim_phase_counter.sv
module pim_phase_counter #(
  parameter int NIBBLE_W = 4,
  parameter int N_STAGES = 2,
  parameter int DIV_LOG  = 4,
  localparam int CNT_W   = NIBBLE_W * N_STAGES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pps_rise,
  input  logic             ref_rise,
  output logic             meas_stb,
  output logic [CNT_W-1:0] meas_val,
  output logic [CNT_W-1:0] cnt_live
);
  localparam logic [CNT_W-1:0] START_VAL = CNT_W'(1);

  logic [DIV_LOG-1:0] div_q, div_d;
  logic               run_q, run_d;
  logic               stb_q, stb_d;
  logic [CNT_W-1:0]   val_q, val_d;
  logic [CNT_W-1:0]   cnt;
  logic               tick, full, inc0;
  logic [N_STAGES-1:0] carry;

  // Divided reference edge: the rise that wraps the divider
  assign tick = ref_rise && (div_q == '1);
  assign full = &cnt;
  assign inc0 = run_q && !tick && !full && !pps_rise;

  assign carry[0] = inc0;
  for (genvar g = 0; g < N_STAGES; g++) begin : g_stage
    pim_count_stage #(.W(NIBBLE_W)) u_stage (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld     (pps_rise),
      .ld_val (START_VAL[g*NIBBLE_W +: NIBBLE_W]),
      .inc    (carry[g]),
      .q      (cnt[g*NIBBLE_W +: NIBBLE_W])
    );
    if (g < N_STAGES - 1) begin : g_carry
      assign carry[g+1] = carry[g] & (&cnt[g*NIBBLE_W +: NIBBLE_W]);
    end
  end

  always_comb begin
    div_d = ref_rise ? div_q + 1'b1 : div_q;
    run_d = run_q;
    stb_d = 1'b0;
    val_d = val_q;
    if (pps_rise) begin
      run_d = 1'b1;
    end else if (run_q && tick) begin
      run_d = 1'b0;
      stb_d = 1'b1;
      val_d = cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      run_q <= 1'b0;
      stb_q <= 1'b0;
      val_q <= '0;
    end else begin
      div_q <= div_d;
      run_q <= run_d;
      stb_q <= stb_d;
      val_q <= val_d;
    end
  end

  assign meas_stb = stb_q;
  assign meas_val = val_q;
  assign cnt_live = cnt;
endmodule

// File: rtl/pim_window_accum.sv
module pim_window_accum #(
  parameter int CNT_W    = 8,
  parameter int ACC_W    = 16,
  parameter int SEL_W    = 3,
  parameter int MAX_SEL  = 6,
  parameter int NORM_LOG = 5,
  localparam int NW      = MAX_SEL + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb,
  input  logic [CNT_W-1:0] val,
  input  logic [SEL_W-1:0] sel,
  output logic             res_valid,
  output logic [ACC_W-1:0] res_value
);
  logic [ACC_W-1:0]   acc_q, acc_d, res_q, res_d, sum;
  logic [MAX_SEL-1:0] n_q, n_d;
  logic               vld_q, vld_d;
  logic [SEL_W-1:0]   sel_eff, sh;
  logic [NW-1:0]      n_next, target;
  logic               last;

  always_comb begin
    sel_eff = (sel > SEL_W'(MAX_SEL)) ? SEL_W'(MAX_SEL) : sel;
    sh      = (sel_eff > SEL_W'(NORM_LOG)) ? sel_eff - SEL_W'(NORM_LOG) : '0;
    n_next  = NW'(n_q) + NW'(1);
    target  = NW'(1) << sel_eff;
    last    = n_next >= target;
    sum     = acc_q + ACC_W'(val);
  end

  always_comb begin
    acc_d = acc_q;
    n_d   = n_q;
    res_d = res_q;
    vld_d = 1'b0;
    if (stb) begin
      if (last) begin
        res_d = sum >> sh;
        vld_d = 1'b1;
        acc_d = '0;
        n_d   = '0;
      end else begin
        acc_d = sum;
        n_d   = n_next[MAX_SEL-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      n_q   <= '0;
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      n_q   <= n_d;
      res_q <= res_d;
      vld_q <= vld_d;
    end
  end

  assign res_valid = vld_q;
  assign res_value = res_q;
endmodule

// File: rtl/phase_interval_meter.sv
module phase_interval_meter #(
  parameter int NIBBLE_W    = 4,
  parameter int N_STAGES    = 2,
  parameter int DIV_LOG     = 4,
  parameter int SEL_W       = 3,
  parameter int MAX_SEL     = 6,
  parameter int NORM_LOG    = 5,
  parameter int ACC_W       = 16,
  parameter int SYS_DIV_LOG = 2,
  localparam int CNT_W      = NIBBLE_W * N_STAGES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pps_in,
  input  logic             ref_in,
  input  logic [SEL_W-1:0] win_sel,
  input  logic             shift_en,
  output logic             sr_out,
  output logic             res_valid,
  output logic [ACC_W-1:0] res_value,
  output logic             sys_clk_out
);
  localparam int RS = pim_pkg::SYNC_DEPTH;

  logic [RS-1:0]          rst_q;
  logic                   rst_sync_n;
  logic                   pps_rise, ref_rise;
  logic                   meas_stb;
  logic [CNT_W-1:0]       meas_val, cnt_live;
  logic [CNT_W-1:0]       sr_q, sr_d;
  logic [SYS_DIV_LOG-1:0] sys_q, sys_d;

  // Reset asserted at once, released after RS clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_q <= '0;
    else
      rst_q <= {rst_q[RS-2:0], 1'b1};
  end
  assign rst_sync_n = rst_q[RS-1];

  pim_sync_edge u_pps_sync (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .async_in (pps_in),
    .rise     (pps_rise)
  );

  pim_sync_edge u_ref_sync (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .async_in (ref_in),
    .rise     (ref_rise)
  );

  pim_phase_counter #(
    .NIBBLE_W (NIBBLE_W),
    .N_STAGES (N_STAGES),
    .DIV_LOG  (DIV_LOG)
  ) u_phase (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .pps_rise (pps_rise),
    .ref_rise (ref_rise),
    .meas_stb (meas_stb),
    .meas_val (meas_val),
    .cnt_live (cnt_live)
  );

  pim_window_accum #(
    .CNT_W    (CNT_W),
    .ACC_W    (ACC_W),
    .SEL_W    (SEL_W),
    .MAX_SEL  (MAX_SEL),
    .NORM_LOG (NORM_LOG)
  ) u_accum (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .stb       (meas_stb),
    .val       (meas_val),
    .sel       (win_sel),
    .res_valid (res_valid),
    .res_value (res_value)
  );

  // Readout register: load on a new reading, else shift on request
  always_comb begin
    sr_d = sr_q;
    if (meas_stb)
      sr_d = meas_val;
    else if (shift_en)
      sr_d = {sr_q[CNT_W-2:0], 1'b0};
    sys_d = sys_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sr_q  <= '0;
      sys_q <= '0;
    end else begin
      sr_q  <= sr_d;
      sys_q <= sys_d;
    end
  end

  assign sr_out      = sr_q[CNT_W-1];
  assign sys_clk_out = sys_q[SYS_DIV_LOG-1];
endmodule

// File: rtl/pim_checker.sv
module pim_checker #(
  parameter int CNT_W = 8,
  parameter int ACC_W = 16,
  parameter int MAX_SEL = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pps_rise,
  input logic             meas_stb,
  input logic [CNT_W-1:0] meas_val,
  input logic [CNT_W-1:0] cnt_live,
  input logic [CNT_W-1:0] sr_q,
  input logic             shift_en,
  input logic             res_valid,
  input logic [ACC_W-1:0] res_value,
  input logic             sys_clk_out
);
  localparam int MAX_SUM = ((1 << CNT_W) - 1) << MAX_SEL;

  AST_COUNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    meas_stb |-> (meas_val != '0)); // R1

  AST_COUNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_live == '1) && !pps_rise) |=> (cnt_live == '1)); // R3

  AST_SERIAL_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !meas_stb) |=> (sr_q == {$past(sr_q[CNT_W-2:0]), 1'b0})); // R4

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid); // R6

  AST_RESULT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (32'(res_value) <= MAX_SUM)); // R6

  AST_SYSCLK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sys_clk_out) |=> $stable(sys_clk_out)); // R7
endmodule

bind phase_interval_meter pim_checker #(
  .CNT_W   (CNT_W),
  .ACC_W   (ACC_W),
  .MAX_SEL (MAX_SEL)
) u_pim_checker (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .pps_rise    (pps_rise),
  .meas_stb    (meas_stb),
  .meas_val    (meas_val),
  .cnt_live    (cnt_live),
  .sr_q        (sr_q),
  .shift_en    (shift_en),
  .res_valid   (res_valid),
  .res_value   (res_value),
  .sys_clk_out (sys_clk_out)
);

// File: tb/test_phase_interval_meter.sv
module test_phase_interval_meter;
  localparam int CLK_PERIOD = 20;
  localparam int SLOT = 240;   // three divided-reference periods
  localparam int VEC_N = 8;
  // pulse offset within a slot, and expected reading (divided edges at 78, 158, 238)
  localparam int VEC_OFF[VEC_N] = '{0, 77, 78, 79, 40, 150, 10, 100};
  localparam int VEC_EXP[VEC_N] = '{78, 1, 80, 79, 38, 8, 68, 58};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pps_in = 1'b0;
  logic        ref_en = 1'b1;
  logic        ref_in;
  logic [2:0]  win_sel = 3'd3;
  logic        shift_en = 1'b0;
  logic        sr_out, res_valid, sys_clk_out;
  logic [15:0] res_value;

  int ncyc = 0;
  int slot = 1;
  int n_chk = 0;
  int n_err = 0;
  int nvalid = 0;
  int last_res = 0;
  int long_pulse = 0;
  bit prev_valid = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) ncyc <= 0;
    else        ncyc <= ncyc + 1;
  end

  // 10 MHz reference: five clock periods, rising where ncyc % 5 == 3
  assign ref_in = ref_en && ((ncyc % 5) >= 3);

  phase_interval_meter i_phase_interval_meter (
    .clk         (clk),
    .rst_n       (rst_n),
    .pps_in      (pps_in),
    .ref_in      (ref_in),
    .win_sel     (win_sel),
    .shift_en    (shift_en),
    .sr_out      (sr_out),
    .res_valid   (res_valid),
    .res_value   (res_value),
    .sys_clk_out (sys_clk_out)
  );

  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      nvalid++;
      last_res = int'(res_value);
      if (prev_valid) long_pulse++;
    end
    prev_valid = res_valid;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_until(input int c);
    while (ncyc < c) @(negedge clk);
  endtask

  task automatic read_serial(output int v);
    v = 0;
    for (int i = 0; i < 8; i++) begin
      v = (v << 1) | int'(sr_out);
      shift_en = 1'b1;
      @(negedge clk);
    end
    shift_en = 1'b0;
  endtask

  task automatic run_slot(input int off, input bit do_read, output int v);
    int s;
    s = SLOT * slot;
    v = -1;
    wait_until(s + off);
    pps_in = 1'b1;
    repeat (5) @(negedge clk);
    pps_in = 1'b0;
    if (do_read) begin
      wait_until(s + 170);
      read_serial(v);
    end
    slot++;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_err++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int v;
    int s;
    int sc[8];
    repeat (4) @(negedge clk);
    // R8: reset state
    check("R8 sr_out in reset", int'(sr_out), 0);
    check("R8 res_valid in reset", int'(res_valid), 0);
    check("R8 res_value in reset", int'(res_value), 0);
    check("R8 sys_clk_out in reset", int'(sys_clk_out), 0);
    rst_n = 1'b1;

    // R7: two high, two low
    repeat (6) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      sc[i] = int'(sys_clk_out);
      @(negedge clk);
    end
    v = 0;
    for (int i = 0; i < 4; i++)
      if (sc[i] != sc[i+4] || sc[i] == sc[i+2]) v++;
    check("R7 quarter-rate system clock pattern mismatches", v, 0);

    // R1 R2 R4: vector table, window of 8 readings
    for (int k = 0; k < VEC_N; k++) begin
      run_slot(VEC_OFF[k], 1'b1, v);
      check($sformatf("R1 R2 R4 reading offset %0d", VEC_OFF[k]), v, VEC_EXP[k]);
      if (k == VEC_N - 2) check("R5 no result before window end", nvalid, 0);
    end
    check("R5 one window after 8 readings", nvalid, 1);
    check("R6 window sum of 8 readings", last_res, 410);

    // R5 R6: one-reading window
    win_sel = 3'd0;
    run_slot(10, 1'b1, v);
    check("R5 one-reading window count", nvalid, 2);
    check("R6 one-reading window value", last_res, 68);

    // R5 R6: 64-reading window halved
    win_sel = 3'd6;
    for (int k = 0; k < 64; k++) begin
      run_slot(78, 1'b0, v);
      if (k == 62) begin
        wait_until(SLOT * slot);
        check("R5 no result after 63 readings", nvalid, 2);
      end
    end
    wait_until(SLOT * slot);
    check("R5 result after 64 readings", nvalid, 3);
    check("R6 64-reading window halved", last_res, 2560);

    // R3: reference missing, count saturates
    win_sel = 3'd0;
    s = SLOT * slot;
    wait_until(s);
    ref_en = 1'b0;
    pps_in = 1'b1;
    repeat (5) @(negedge clk);
    pps_in = 1'b0;
    wait_until(s + 300);
    ref_en = 1'b1;
    v = 0;
    while (nvalid < 4 && v < 300) begin
      @(negedge clk);
      v++;
    end
    repeat (3) @(negedge clk);
    read_serial(v);
    check("R3 saturated serial reading", v, 255);
    check("R3 saturated window value", last_res, 255);
    check("R4 zero fill after eight shifts", int'(sr_out), 0);
    check("R6 valid strobe wider than one cycle", long_pulse, 0);

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule